// File: doc/BRIEF.md
# Completion Interrupt Coalescer

This block sits in one channel of a descriptor-driven transfer engine and decides when packet completions should become interrupts. It keeps a down-counter, loaded from an 8-bit threshold, that counts completed packets. It also keeps an 8-bit delay timer that restarts on each completion, so the timer measures idle time since the last packet. When enough packets have finished, the block emits a one-cycle complete-set pulse. When the channel has been quiet for the programmed delay, it emits a one-cycle delay-set pulse. The flag registers, the clear-on-write logic and the interrupt masks that consume these pulses are outside the block.

Both settings come from the channel control word: the threshold sits in bits [23:16] and the delay in bits [31:24]. The control-write strobe tells the block that software has rewritten that word. The timer advances only on cycles where the tick enable is high, so a prescaler elsewhere sets the time base. The current count and timer value are brought out for status readback.

Top module: `irq_coalescer`

## Requirements
- R1: After reset the count output is 1, the timer output is 0, and both set pulses are low.
- R2: Each completion decrements the count. If the decremented value is zero, the complete-set pulse is high for exactly one cycle, in the cycle after the completion, and the count reloads from the threshold (control bits [23:16]).
- R3: With a count of 0, a completion wraps the count to 255 and raises no complete-set pulse.
- R4: A completion while the delay (control bits [31:24]) is nonzero loads the timer with the delay and discards any run in progress.
- R5: A completion while the delay is zero leaves the timer untouched. An idle timer (value 0) never starts by itself.
- R6: A nonzero timer decrements by one on each cycle with the tick enable high. It holds its value when tick is low and stays at 0 once there.
- R7: A tick while the timer reads 1 is an expiry. The delay-set pulse is high for one cycle in the next cycle, and the count reloads from the threshold.
- R8: A control-write strobe reloads the count from the threshold. It takes priority over a completion and over an expiry for the count, and a completion in that cycle then raises no complete-set pulse.
- R9: When a completion and an expiry fall in the same cycle, the delay-set pulse is still issued. The count follows the completion rule and the timer follows the completion rule of R4 and R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_word_i | input | 32 | Channel control word: threshold in [23:16], delay in [31:24] |
| ctrl_wr_i | input | 1 | Control word was written this cycle |
| cmpl_i | input | 1 | One-cycle packet-completion event |
| tick_i | input | 1 | Timer tick enable |
| ioc_set_o | output | 1 | One-cycle complete-set pulse |
| dly_set_o | output | 1 | One-cycle delay-set pulse |
| count_o | output | 8 | Current coalescing count |
| timer_o | output | 8 | Current delay timer value |

## Verification
Every result is due one clock edge after the inputs that cause it. The count, the timer value and both pulses are registered, so the inputs sampled at edge N show up at the outputs right after edge N. The bench drives inputs on the falling edge and advances a reference model at the rising edge. It then compares all four outputs on the next falling edge, before it changes any input. Directed cases cover wrap-around, zero delay, expiry, collision and write priority, and seeded random traffic covers everything in between.

// File: rtl/coal_pkg.sv
package coal_pkg;
    localparam int CNT_W = 8;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ioc;
    } cnt_state_t;

    typedef struct packed {
        logic [CNT_W-1:0] tmr;
        logic             dly;
    } tmr_state_t;
endpackage

// File: rtl/coal_count.sv
module coal_count
    import coal_pkg::*;
#(
    parameter logic [CNT_W-1:0] RESET_COUNT = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] thr_i,
    input  logic             reload_i,
    input  logic             cmpl_i,
    input  logic             expire_i,
    output logic [CNT_W-1:0] count_o,
    output logic             ioc_set_o
);
    cnt_state_t s_d, s_q;
    logic [CNT_W-1:0] dec_d;

    always_comb begin
        s_d     = s_q;
        s_d.ioc = 1'b0;
        dec_d   = s_q.cnt - 1'b1;
        if (reload_i) begin
            s_d.cnt = thr_i;
        end else if (cmpl_i) begin
            if (dec_d == '0) begin
                s_d.ioc = 1'b1;
                s_d.cnt = thr_i;
            end else begin
                s_d.cnt = dec_d;
            end
        end else if (expire_i) begin
            s_d.cnt = thr_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.cnt <= RESET_COUNT;
            s_q.ioc <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign count_o   = s_q.cnt;
    assign ioc_set_o = s_q.ioc;

    // R2: a complete-set pulse always leaves the count at the prior threshold
    p_ioc_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ioc_set_o |-> (count_o == $past(thr_i)));

    // R8: control write reloads the count
    p_wr_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reload_i |=> (count_o == $past(thr_i)) && !ioc_set_o);

    // R3: completion from zero wraps without a pulse
    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl_i && !reload_i && count_o == '0) |=> (count_o == '1) && !ioc_set_o);
endmodule

// File: rtl/coal_timer.sv
module coal_timer
    import coal_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] delay_i,
    input  logic             cmpl_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] timer_o,
    output logic             expire_o,
    output logic             dly_set_o
);
    tmr_state_t s_d, s_q;
    logic       hit_d;

    always_comb begin
        hit_d   = tick_i && (s_q.tmr == CNT_W'(1));
        s_d     = s_q;
        s_d.dly = hit_d;
        if (cmpl_i && (delay_i != '0)) begin
            s_d.tmr = delay_i;
        end else if (tick_i && (s_q.tmr != '0)) begin
            s_d.tmr = s_q.tmr - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.tmr <= '0;
            s_q.dly <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign timer_o   = s_q.tmr;
    assign expire_o  = hit_d;
    assign dly_set_o = s_q.dly;

    // R4: completion with nonzero delay restarts the timer
    p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl_i && delay_i != '0) |=> (timer_o == $past(delay_i)));

    // R5: an idle timer stays idle without a loading completion
    p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_o == '0 && !(cmpl_i && delay_i != '0)) |=> (timer_o == '0));

    // R6: no tick, no load, no change
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !cmpl_i) |=> $stable(timer_o));
endmodule

// File: rtl/irq_coalescer.sv
module irq_coalescer
    import coal_pkg::*;
#(
    parameter int CTRL_W = 32,
    parameter int THR_LSB = 16,
    parameter int DLY_LSB = 24,
    parameter logic [CNT_W-1:0] RESET_COUNT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] ctrl_word_i,
    input  logic              ctrl_wr_i,
    input  logic              cmpl_i,
    input  logic              tick_i,
    output logic              ioc_set_o,
    output logic              dly_set_o,
    output logic [CNT_W-1:0]  count_o,
    output logic [CNT_W-1:0]  timer_o
);
    logic [CNT_W-1:0] thr_w, delay_w;
    logic             expire_w;

    assign thr_w   = ctrl_word_i[THR_LSB +: CNT_W];
    assign delay_w = ctrl_word_i[DLY_LSB +: CNT_W];

    coal_timer u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .delay_i  (delay_w),
        .cmpl_i   (cmpl_i),
        .tick_i   (tick_i),
        .timer_o  (timer_o),
        .expire_o (expire_w),
        .dly_set_o(dly_set_o)
    );

    coal_count #(.RESET_COUNT(RESET_COUNT)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .thr_i    (thr_w),
        .reload_i (ctrl_wr_i),
        .cmpl_i   (cmpl_i),
        .expire_i (expire_w),
        .count_o  (count_o),
        .ioc_set_o(ioc_set_o)
    );

    // R7: a lone expiry reloads the count
    p_expiry_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dly_set_o && !$past(cmpl_i) && !$past(ctrl_wr_i)) |-> (count_o == $past(thr_w)));

    // R7: expiry pulse follows a tick at timer value one
    p_expiry_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && timer_o == CNT_W'(1)) |=> dly_set_o);
endmodule

// File: tb/sim_irq_coalescer.sv
`timescale 1ns/1ps
module sim_irq_coalescer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ctrl_word = '0;
    logic        ctrl_wr = 1'b0, cmpl = 1'b0, tick = 1'b0;
    logic        ioc_set, dly_set;
    logic [7:0]  count, timer;

    int n_cmp = 0, n_bad = 0;
    logic [7:0] m_cnt, m_tmr;
    logic       m_ioc, m_dly;

    always #4 clk = ~clk;

    irq_coalescer u0 (
        .clk(clk), .rst_n(rst_n), .ctrl_word_i(ctrl_word), .ctrl_wr_i(ctrl_wr),
        .cmpl_i(cmpl), .tick_i(tick), .ioc_set_o(ioc_set), .dly_set_o(dly_set),
        .count_o(count), .timer_o(timer)
    );

    function automatic logic [31:0] mk(input logic [7:0] thr, input logic [7:0] dly);
        return {dly, thr, 16'h0000};
    endfunction

    task automatic model_step();
        logic [7:0] thr = ctrl_word[23:16];
        logic [7:0] dly = ctrl_word[31:24];
        logic       hit = tick && (m_tmr == 8'd1);
        logic [7:0] dec = m_cnt - 8'd1;
        m_ioc = 1'b0;
        m_dly = hit;
        if (ctrl_wr) m_cnt = thr;
        else if (cmpl) begin
            if (dec == 8'd0) begin m_ioc = 1'b1; m_cnt = thr; end
            else m_cnt = dec;
        end else if (hit) m_cnt = thr;
        if (cmpl && dly != 8'd0) m_tmr = dly;
        else if (tick && m_tmr != 8'd0) m_tmr = m_tmr - 8'd1;
    endtask

    task automatic chk(input string tag);
        n_cmp++;
        if ({count, timer, ioc_set, dly_set} !== {m_cnt, m_tmr, m_ioc, m_dly}) begin
            n_bad++;
            $display("FAIL %s: cnt/tmr/ioc/dly actual %0d/%0d/%0b/%0b expected %0d/%0d/%0b/%0b",
                     tag, count, timer, ioc_set, dly_set, m_cnt, m_tmr, m_ioc, m_dly);
        end
    endtask

    task automatic step(input logic wr, input logic [31:0] cw, input logic c,
                        input logic t, input string tag);
        ctrl_wr = wr; ctrl_word = cw; cmpl = c; tick = t;
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk(tag);
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_cnt = 8'd1; m_tmr = 8'd0; m_ioc = 1'b0; m_dly = 1'b0;
        chk("R1 reset state");

        // R8 write, R2 count to threshold with zero delay (R5)
        step(1, mk(8'd3, 8'd0), 0, 0, "R8 write reload");
        step(0, mk(8'd3, 8'd0), 1, 1, "R2 first completion");
        step(0, mk(8'd3, 8'd0), 1, 0, "R5 zero delay keeps timer idle");
        step(0, mk(8'd3, 8'd0), 1, 0, "R2 threshold reached pulse");
        step(0, mk(8'd3, 8'd0), 0, 0, "R2 pulse one cycle");
        // R3 wrap with threshold zero
        step(1, mk(8'd0, 8'd0), 0, 0, "R8 load zero threshold");
        step(0, mk(8'd0, 8'd0), 1, 0, "R3 wrap to 255");
        // R4/R6/R7 delay run
        step(1, mk(8'd5, 8'd3), 0, 0, "R8 reload five");
        step(0, mk(8'd5, 8'd3), 1, 0, "R4 timer loads delay");
        step(0, mk(8'd5, 8'd3), 0, 0, "R6 hold without tick");
        step(0, mk(8'd5, 8'd3), 0, 1, "R6 tick decrement");
        step(0, mk(8'd5, 8'd3), 1, 1, "R4 restart discards run");
        step(0, mk(8'd5, 8'd3), 0, 1, "R6 tick");
        step(0, mk(8'd5, 8'd3), 0, 1, "R6 tick to one");
        step(0, mk(8'd5, 8'd3), 0, 1, "R7 expiry pulse and reload");
        step(0, mk(8'd5, 8'd3), 0, 1, "R6 stays at zero");
        // R9 collision
        step(0, mk(8'd5, 8'd2), 1, 0, "R4 load two");
        step(0, mk(8'd5, 8'd2), 0, 1, "R6 tick to one");
        step(0, mk(8'd5, 8'd2), 1, 1, "R9 collision completion and expiry");
        // R8 write beats completion at count one
        step(1, mk(8'd1, 8'd0), 0, 0, "R8 threshold one");
        step(1, mk(8'd1, 8'd0), 1, 0, "R8 write beats completion no pulse");

        for (int i = 0; i < 4000; i++) begin
            logic [7:0] thr = 8'($urandom % 4);
            logic [7:0] dly = 8'($urandom % 6);
            step(($urandom % 20) == 0, mk(thr, dly), ($urandom % 4) == 0,
                 ($urandom % 2) == 0, "R2 R7 R9 random traffic");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule